// File: doc/BRIEF.md
# Configuration Command Block Parser

This block receives a configuration byte stream and splits it into command blocks. Bytes arrive one per valid/ready handshake. Each block holds:

- a command code;
- a length field;
- a two-byte header check;
- the declared number of payload bytes;
- a two-byte check over the whole block.

The parser reports the command code and the decoded length once the header is complete, together with a flag saying whether the header check matched. It then streams out the payload bytes, marking the final one. At the end of the block it raises a completion pulse with a flag saying whether the block check matched.

Both checks use the reflected CRC-16 (polynomial 0x1021, bit-reversed form 0x8408) with a starting value of 0xFFFF and a final inversion with 0xFFFF. Between blocks, the stream may carry filler bytes, which the parser drops. A byte between blocks that is neither filler nor a known command raises an error pulse. The first block after reset must be the path-select command; if it is another command, a start error is reported.

Downstream logic acts on the commands. This block only frames and checks them.

Top module: `cfg_block_parser`

## Requirements
- R1: After reset, all pulse outputs (`hdr_valid`, `pay_valid`, `pay_last`, `blk_valid`, `unk_err`, `start_err`) are low, both CRC flags are low, and `in_ready` is high.
- R2: Between blocks, the filler bytes 0x00 and 0x33 are discarded and produce no output pulse of any kind.
- R3: Between blocks, a byte is a known command only if it is one of 0xC1, 0xC2, 0xC3, 0xC5, 0xC6, 0xC7, 0xC8, 0xC9, 0xCA, 0xCC, 0xCE, 0xD2, 0xD7, 0xD8, 0xD9, 0xDA, 0xDB, 0xDC, 0xDD or 0xDE. Any other non-filler byte there is dropped, and `unk_err` pulses in the cycle after it is accepted.
- R4: For command 0xD2, the length field is two bytes, low byte first. For every other command it is one byte, and the upper bits of `out_len` read zero.
- R5: The header CRC covers the command byte and the length bytes, and its final value is sent high byte first. `hdr_valid` pulses for one cycle after the second header CRC byte, with `out_cmd`, `out_len` and `hdr_crc_ok` valid.
- R6: The block CRC covers every earlier byte of the block, including both header CRC bytes as received, and is also sent high byte first. `blk_valid` pulses for one cycle after the last byte, with `blk_crc_ok` valid.
- R7: A block with length n produces exactly n `pay_valid` beats. Each beat appears one cycle after its byte is accepted, carries that byte in stream order, and `pay_last` is set only on the n-th beat.
- R8: A block with length zero goes from the header CRC directly to the block CRC and produces no payload beat.
- R9: When the header CRC does not match, `hdr_crc_ok` is low, but the declared length still decides where the block ends.
- R10: If the first known command after reset is not 0xD9, `start_err` pulses once, in the cycle after that command byte is accepted, and the block is still parsed. If the first known command is 0xD9, `start_err` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input ready, always high |
| hdr_valid | output | 1 | Header complete pulse |
| out_cmd | output | 8 | Command code of the current block |
| out_len | output | 16 | Decoded payload length |
| hdr_crc_ok | output | 1 | Header CRC matched |
| pay_valid | output | 1 | Payload byte valid |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the block |
| blk_valid | output | 1 | Block complete pulse |
| blk_crc_ok | output | 1 | Block CRC matched |
| unk_err | output | 1 | Unknown byte between blocks |
| start_err | output | 1 | First command was not path select |

## Verification
Blocks are built with random commands, random lengths and random payloads, and random filler bytes are placed between them.

Directed blocks add the corner cases:
- a two-byte length above 255, which separates the low-byte-first decoding from the reverse order;
- a zero length;
- a corrupted header check, which shows that the length still frames the block;
- a corrupted block check, which shows that the two checks are independent.

Stray unknown bytes and a stream that starts with the wrong command separate the two error pulses from each other and from the silent dropping of filler.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LEN0, S_LEN1, S_HC0, S_HC1, S_PAY, S_BC0, S_BC1
  } pstate_e;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_SEED      = 16'hFFFF;
  localparam logic [15:0] CRC_FIN_XOR   = 16'hFFFF;

  // One byte of reflected CRC-16, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic cmd_is_known(input logic [7:0] b);
    case (b)
      8'hC1, 8'hC2, 8'hC3, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCC,
      8'hCE, 8'hD2, 8'hD7, 8'hD8, 8'hD9, 8'hDA, 8'hDB, 8'hDC, 8'hDD, 8'hDE:
        return 1'b1;
      default:
        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_crc16.sv
module cfgp_crc16
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] fin_nxt
);
  logic [15:0] crc_q;
  logic [15:0] crc_nxt;

  assign crc_nxt = crc16_step(crc_q, din);
  assign fin_nxt = crc_nxt ^ CRC_FIN_XOR;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= CRC_SEED;
    else if (upd)      crc_q <= crc_nxt;
  end
endmodule

// File: rtl/cfgp_cmd_lookup.sv
module cfgp_cmd_lookup
  import cfgp_pkg::*;
#(
  parameter logic [7:0] WIDE_CODE = 8'hD2,
  parameter logic [7:0] NOP_CODE  = 8'h00,
  parameter logic [7:0] EXEC_CODE = 8'h33
) (
  input  logic [7:0] code,
  output logic       known,
  output logic       wide,
  output logic       filler
);
  assign known  = cmd_is_known(code);
  assign wide   = (code == WIDE_CODE);
  assign filler = (code == NOP_CODE) || (code == EXEC_CODE);
endmodule

// File: rtl/cfgp_beat_cnt.sv
module cfgp_beat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q;

  assign last = (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/cfg_block_parser.sv
module cfg_block_parser
  import cfgp_pkg::*;
#(
  parameter int         LEN_W     = 16,
  parameter logic [7:0] FIRST_CMD = 8'hD9,
  parameter logic [7:0] WIDE_CMD  = 8'hD2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             hdr_valid,
  output logic [7:0]       out_cmd,
  output logic [LEN_W-1:0] out_len,
  output logic             hdr_crc_ok,
  output logic             pay_valid,
  output logic [7:0]       pay_data,
  output logic             pay_last,
  output logic             blk_valid,
  output logic             blk_crc_ok,
  output logic             unk_err,
  output logic             start_err
);
  localparam int HI_W = LEN_W - 8;

  pstate_e          state_q;
  logic [7:0]       cmd_q;
  logic [LEN_W-1:0] len_q;
  logic [15:0]      hdr_ref_q, blk_ref_q;
  logic [7:0]       rx_hi_q;
  logic             first_done_q;

  // Named internal events, brought out for the checker.
  logic acc, st_idle, cmd_known, cmd_wide, cmd_filler, cnt_last;
  logic crc_upd, crc_clr, cnt_load, cnt_dec;
  logic [15:0] crc_fin;

  assign in_ready = 1'b1;
  assign acc      = in_valid;
  assign st_idle  = (state_q == S_IDLE);
  assign out_cmd  = cmd_q;
  assign out_len  = len_q;

  assign crc_clr  = acc && (state_q == S_BC1);
  assign crc_upd  = acc && (!st_idle || cmd_known);
  assign cnt_load = acc && (state_q == S_HC1);
  assign cnt_dec  = acc && (state_q == S_PAY);

  cfgp_cmd_lookup #(.WIDE_CODE(WIDE_CMD)) u_lookup (
    .code(in_data), .known(cmd_known), .wide(cmd_wide), .filler(cmd_filler)
  );

  cfgp_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
    .din(in_data), .fin_nxt(crc_fin)
  );

  cfgp_beat_cnt #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(len_q),
    .dec(cnt_dec), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      cmd_q        <= '0;
      len_q        <= '0;
      hdr_ref_q    <= '0;
      blk_ref_q    <= '0;
      rx_hi_q      <= '0;
      first_done_q <= 1'b0;
      hdr_valid    <= 1'b0;
      hdr_crc_ok   <= 1'b0;
      pay_valid    <= 1'b0;
      pay_data     <= '0;
      pay_last     <= 1'b0;
      blk_valid    <= 1'b0;
      blk_crc_ok   <= 1'b0;
      unk_err      <= 1'b0;
      start_err    <= 1'b0;
    end else begin
      hdr_valid <= 1'b0;
      pay_valid <= 1'b0;
      pay_last  <= 1'b0;
      blk_valid <= 1'b0;
      unk_err   <= 1'b0;
      start_err <= 1'b0;
      if (acc) begin
        unique case (state_q)
          S_IDLE: begin
            if (cmd_filler) begin
              state_q <= S_IDLE;
            end else if (cmd_known) begin
              cmd_q        <= in_data;
              first_done_q <= 1'b1;
              if (!first_done_q && in_data != FIRST_CMD) start_err <= 1'b1;
              state_q <= S_LEN0;
            end else begin
              unk_err <= 1'b1;
            end
          end
          S_LEN0: begin
            len_q <= LEN_W'(in_data);
            if (cmd_q == WIDE_CMD) begin
              state_q <= S_LEN1;
            end else begin
              hdr_ref_q <= crc_fin;
              state_q   <= S_HC0;
            end
          end
          S_LEN1: begin
            len_q     <= {in_data[HI_W-1:0], len_q[7:0]};
            hdr_ref_q <= crc_fin;
            state_q   <= S_HC0;
          end
          S_HC0: begin
            rx_hi_q <= in_data;
            state_q <= S_HC1;
          end
          S_HC1: begin
            hdr_valid  <= 1'b1;
            hdr_crc_ok <= ({rx_hi_q, in_data} == hdr_ref_q);
            if (len_q == '0) begin
              blk_ref_q <= crc_fin;
              state_q   <= S_BC0;
            end else begin
              state_q <= S_PAY;
            end
          end
          S_PAY: begin
            pay_valid <= 1'b1;
            pay_data  <= in_data;
            if (cnt_last) begin
              pay_last  <= 1'b1;
              blk_ref_q <= crc_fin;
              state_q   <= S_BC0;
            end
          end
          S_BC0: begin
            rx_hi_q <= in_data;
            state_q <= S_BC1;
          end
          S_BC1: begin
            blk_valid  <= 1'b1;
            blk_crc_ok <= ({rx_hi_q, in_data} == blk_ref_q);
            state_q    <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic             st_idle,
  input logic             cmd_known,
  input logic             cmd_filler,
  input logic             hdr_valid,
  input logic [LEN_W-1:0] out_len,
  input logic             pay_valid,
  input logic             pay_last,
  input logic             blk_valid,
  input logic             unk_err,
  input logic             start_err
);
  a_r2_filler_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    acc && st_idle && cmd_filler |=> !unk_err && !start_err && !hdr_valid && !pay_valid);

  a_r3_unknown_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    acc && st_idle && !cmd_known && !cmd_filler |=> unk_err);

  a_r7_last_is_beat: assert property (@(posedge clk) disable iff (!rst_n)
    pay_last |-> pay_valid);

  a_r8_zero_len_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && out_len == '0 |=> !pay_valid);

  a_r10_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |=> !start_err);

  a_r6_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_valid, blk_valid, unk_err}));
endmodule

bind cfg_block_parser cfgp_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .st_idle(st_idle),
  .cmd_known(cmd_known), .cmd_filler(cmd_filler), .hdr_valid(hdr_valid),
  .out_len(out_len), .pay_valid(pay_valid), .pay_last(pay_last),
  .blk_valid(blk_valid), .unk_err(unk_err), .start_err(start_err)
);

// File: tb/sim_cfg_block_parser.sv
module sim_cfg_block_parser;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, hdr_valid, hdr_crc_ok, pay_valid, pay_last, blk_valid, blk_crc_ok;
  logic unk_err, start_err;
  logic [7:0] out_cmd, pay_data;
  logic [15:0] out_len;

  always #10 clk = ~clk;

  cfg_block_parser u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int n_hdr, n_pay, n_last, n_blk, n_unk, n_start, n_mis, pay_base;
  logic [7:0]  g_cmd;
  logic [15:0] g_len;
  logic g_hok, g_bok;
  logic [7:0] bb [0:1023];

  localparam logic [7:0] KNOWN [0:19] = '{8'hC1, 8'hC2, 8'hC3, 8'hC5, 8'hC6,
    8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCC, 8'hCE, 8'hD2, 8'hD7, 8'hD8, 8'hD9,
    8'hDA, 8'hDB, 8'hDC, 8'hDD, 8'hDE};

  // Bench CRC: bit-serial feedback form over bb[0..n-1].
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ bb[k][i];
        c = {1'b0, c[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
      end
    return ~c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_hdr = 0; n_pay = 0; n_last = 0; n_blk = 0; n_unk = 0; n_start = 0; n_mis = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (hdr_valid) begin n_hdr++; g_cmd = out_cmd; g_len = out_len; g_hok = hdr_crc_ok; end
    if (pay_valid) begin
      if (pay_data != bb[pay_base + n_pay]) n_mis++;
      n_pay++;
    end
    if (pay_last)  n_last++;
    if (blk_valid) begin n_blk++; g_bok = blk_crc_ok; end
    if (unk_err)   n_unk++;
    if (start_err) n_start++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic block(input logic [7:0] cmd, input int len, input bit bad_h, input bit bad_b);
    int n = 0;
    logic [15:0] hc, bc;
    bb[n++] = cmd;
    bb[n++] = len[7:0];
    if (cmd == 8'hD2) bb[n++] = len[15:8];
    hc = ref_crc(n) ^ (bad_h ? 16'h0100 : 16'h0000);
    bb[n++] = hc[15:8];
    bb[n++] = hc[7:0];
    pay_base = n;
    for (int i = 0; i < len; i++) bb[n++] = 8'($urandom);
    bc = ref_crc(n) ^ (bad_b ? 16'h0001 : 16'h0000);
    bb[n++] = bc[15:8];
    bb[n++] = bc[7:0];
    clr_mon();
    for (int i = 0; i < n; i++) send(bb[i]);
    chk(n_hdr == 1 && g_cmd == cmd, "R5 header pulse/cmd", int'(g_cmd), int'(cmd));
    chk(g_len == 16'(len), "R4 length", int'(g_len), len);
    chk(g_hok == !bad_h, "R5 header crc flag", int'(g_hok), int'(!bad_h));
    chk(n_pay == len && n_mis == 0, "R7 payload beats", n_pay - n_mis, len);
    chk(n_last == (len > 0 ? 1 : 0), "R7 last marker", n_last, len > 0 ? 1 : 0);
    chk(n_blk == 1 && g_bok == !bad_b, "R6 block crc flag", int'(g_bok), int'(!bad_b));
    chk(n_unk == 0, "R3 no stray unknown", n_unk, 0);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    do_reset();
    #1;
    chk(!hdr_valid && !pay_valid && !pay_last && !blk_valid && !unk_err && !start_err
        && !hdr_crc_ok && !blk_crc_ok && in_ready, "R1 reset state", 0, 0);

    // R2: filler ignored; R3: unknown flagged, not counted as first block
    clr_mon();
    send(8'h00); send(8'h33); send(8'h00);
    chk(n_unk == 0 && n_start == 0 && n_hdr == 0 && n_pay == 0, "R2 filler silent", n_unk, 0);
    send(8'h55);
    chk(n_unk == 1 && n_start == 0, "R3 unknown pulse", n_unk, 1);

    // R10: wrong first command
    clr_mon();
    bb[0] = 8'hC1;
    send(8'hC1);
    chk(n_start == 1, "R10 start error raised", n_start, 1);
    send(8'h00); send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF);
    // finish a block later; reset to start clean
    do_reset();
    block(8'hD9, 3, 0, 0);
    chk(n_start == 0, "R10 no start error on path select", n_start, 0);
    block(8'hC1, 5, 0, 0);
    chk(n_start == 0, "R10 only first block tested", n_start, 0);

    // R4: two-byte length above 255 and R8 zero length
    block(8'hD2, 300, 0, 0);
    block(8'hD2, 0, 0, 0);
    block(8'hC7, 0, 0, 0);
    chk(n_pay == 0, "R8 no beat on zero length", n_pay, 0);
    // R9: header mismatch still framed by length; R6 corrupted block check
    block(8'hCA, 7, 1, 0);
    block(8'hCA, 9, 0, 1);
    clr_mon();
    send(8'h00); send(8'h33); send(8'h00);
    chk(n_unk == 0 && n_hdr == 0, "R9 framing held after bad header", n_unk, 0);

    // Random blocks with random filler
    for (int r = 0; r < 40; r++) begin
      int nf = $urandom_range(0, 3);
      for (int f = 0; f < nf; f++) send($urandom_range(0, 1) ? 8'h33 : 8'h00);
      begin
        logic [7:0] c = KNOWN[$urandom_range(0, 19)];
        int l = (c == 8'hD2 && $urandom_range(0, 3) == 0) ? $urandom_range(256, 400)
                                                         : $urandom_range(0, 40);
        block(c, l, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule